// File: doc/BRIEF.md
# ADC Conversion Phase Sequencer

This block is a cycle-level model of the control logic that steps a sampling converter through its operating phases. A host drives a convert-start line and an active-low chip select. The sequencer first qualifies the convert-start line with chip select through a clocked latch. That latch follows convert-start only while select is low and holds its value otherwise. The sequencer watches the qualified line for a falling edge, which begins a conversion.

The sequencer has four phases: wait, nap, sample and convert. Conversion takes a fixed number of clock cycles, set by a parameter, and a busy flag is high for exactly that span. If the host keeps select low with convert-start high when a conversion ends, the block goes straight back to sampling with no idle gap. This gives the highest throughput. Otherwise it drops to wait. After a parameterised number of idle cycles in wait it moves on to nap.

Top module: `convphase_seq`

## Requirements
- R1: While reset is asserted and on release, the phase output reads 00 (wait), busy is 0 and the qualified convert output is 0.
- R2: On every clock edge where chip select is sampled low, the qualified convert output takes the sampled convert-start value. On an edge where chip select is high, it keeps its previous value.
- R3: In wait (00) or nap (01), an edge that samples convert-start high and chip select low moves the phase to sample (10).
- R4: In sample (10), the phase becomes convert (11) on the first edge after the edge on which the qualified convert output fell from 1 to 0.
- R5: Busy is high exactly while the phase is convert, and each conversion lasts exactly CONV_CYCLES clock cycles.
- R6: If the edge that ends a conversion samples convert-start high and chip select low, the next phase is sample (10), with no wait or nap cycle in between.
- R7: If the edge that ends a conversion does not sample that condition, the next phase is wait (00).
- R8: After NAP_IDLE consecutive cycles in wait with no start condition, the phase becomes nap (01). Nap is entered only from wait.
- R9: A falling edge of the qualified convert output during a conversion has no effect: the conversion runs its full length and does not restart.
- R10: The phase output encodes wait as 00, nap as 01, sample as 10 and convert as 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Convert-start request from the host |
| sel_n | input | 1 | Active-low chip select that gates the qualifying latch |
| busy | output | 1 | High for the duration of a conversion |
| qual_start | output | 1 | Convert-start as seen through the select-gated latch |
| phase | output | 2 | Current phase code (00 wait, 01 nap, 10 sample, 11 convert) |

## Verification
The bench steers the sequencer through back-to-back chains in which convert-start is raised during the final conversion cycle. A design that inserts an idle cycle would show 00 between the end of busy and sample. It toggles convert-start while select is high, which catches a latch that leaks through when it should hold. It also pulses a falling edge in the middle of a conversion, which would shorten or restart busy in a design that fails to ignore it. Long idle stretches probe the nap threshold, where an off-by-one counter would enter 01 one cycle early or late.

// File: rtl/cps_pkg.sv
// Package: shared phase encoding for the conversion phase sequencer.
// Assumes: a 2-bit phase code that downstream logic decodes directly.
package cps_pkg;

    typedef enum logic [1:0] {
        PH_WAIT   = 2'b00,
        PH_NAP    = 2'b01,
        PH_SAMPLE = 2'b10,
        PH_CONV   = 2'b11
    } phase_e;

endpackage

// File: rtl/cps_convst_qual.sv
// Module: cps_convst_qual
// Qualifies the convert-start request with chip select. The register
// follows start_req on edges where sel_n is low and holds otherwise,
// standing in for a level latch in a cycle-based model. A one-cycle
// falling-edge strobe is derived from the current and previous value.
// Assumes: start_req and sel_n are synchronous to clk.
module cps_convst_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic sel_n,
    output logic qual,
    output logic fall
);

    logic qual_q;
    logic qual_prev_q;

    // Select-gated capture of the convert-start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q <= 1'b0;
        end else if (!sel_n) begin
            qual_q <= start_req;
        end
    end

    // One-cycle history of the qualified value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_prev_q <= 1'b0;
        end else begin
            qual_prev_q <= qual_q;
        end
    end

    // Strobe a falling edge of the qualified convert signal.
    always_comb begin
        fall = qual_prev_q & ~qual_q;
    end

    assign qual = qual_q;

endmodule

// File: rtl/cps_cycle_timer.sv
// Module: cps_cycle_timer
// Counts cycles while run is high and clears whenever run is low.
// done is high in the LIMIT-th consecutive running cycle and the count
// holds there until run drops.
// Assumes: LIMIT >= 1; the owner drops run on the edge after done.
module cps_cycle_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] count_q;

    // Terminal-count decode while running.
    always_comb begin
        done = run && (count_q == LAST);
    end

    // Cycle counter, cleared outside the timed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run) begin
            count_q <= '0;
        end else if (!done) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/cps_phase_fsm.sv
// Module: cps_phase_fsm
// Phase state machine: wait, nap, sample and convert. Sampling starts
// from wait or nap on the start condition. Conversion starts on a
// qualified falling edge seen in sample. At the end of a conversion the
// machine chains back to sample or drops to wait. Falling edges seen
// outside sample are ignored.
// Assumes: conv_done and idle_done come from timers run by this phase.
module cps_phase_fsm
    import cps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    input  logic   fall,
    input  logic   conv_done,
    input  logic   idle_done,
    output phase_e phase
);

    phase_e phase_q;
    phase_e phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_WAIT: begin
                if (go) begin
                    phase_d = PH_SAMPLE;
                end else if (idle_done) begin
                    phase_d = PH_NAP;
                end
            end
            PH_NAP: begin
                if (go) begin
                    phase_d = PH_SAMPLE;
                end
            end
            PH_SAMPLE: begin
                if (fall) begin
                    phase_d = PH_CONV;
                end
            end
            PH_CONV: begin
                if (conv_done) begin
                    phase_d = go ? PH_SAMPLE : PH_WAIT;
                end
            end
            default: phase_d = PH_WAIT;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WAIT;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/convphase_seq.sv
// Module: convphase_seq (top)
// Converter phase sequencer: qualifies convert-start with chip select,
// times conversions and idle periods, and reports the phase and busy.
// Assumes: inputs synchronous to clk; CONV_CYCLES and NAP_IDLE >= 1.
module convphase_seq #(
    parameter int CONV_CYCLES = 20,
    parameter int NAP_IDLE    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       sel_n,
    output logic       busy,
    output logic       qual_start,
    output logic [1:0] phase
);
    import cps_pkg::*;

    localparam int N_TIMERS = 2;
    localparam int T_CONV   = 0;
    localparam int T_IDLE   = 1;

    phase_e             cur_phase;
    logic               go;
    logic               fall;
    logic [N_TIMERS-1:0] t_run;
    logic [N_TIMERS-1:0] t_done;

    // Start condition: request high with chip select low.
    always_comb begin
        go = start_req & ~sel_n;
    end

    cps_convst_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .sel_n     (sel_n),
        .qual      (qual_start),
        .fall      (fall)
    );

    // Timer enables: conversion length and idle-to-nap threshold.
    always_comb begin
        t_run[T_CONV] = (cur_phase == PH_CONV);
        t_run[T_IDLE] = (cur_phase == PH_WAIT);
    end

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
        localparam int LIM = (g == T_CONV) ? CONV_CYCLES : NAP_IDLE;
        cps_cycle_timer #(
            .LIMIT (LIM)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (t_run[g]),
            .done  (t_done[g])
        );
    end

    cps_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .fall      (fall),
        .conv_done (t_done[T_CONV]),
        .idle_done (t_done[T_IDLE]),
        .phase     (cur_phase)
    );

    // Output decode.
    always_comb begin
        busy  = (cur_phase == PH_CONV);
        phase = cur_phase;
    end

endmodule

// File: rtl/convphase_seq_chk.sv
// Module: convphase_seq_chk
// Property checker bound to convphase_seq. It observes the ports only
// and keeps its own busy run-length counter for the conversion window.
module convphase_seq_chk #(
    parameter int CONV_CYCLES = 20,
    parameter int NAP_IDLE    = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       sel_n,
    input logic       busy,
    input logic       qual_start,
    input logic [1:0] phase
);

    localparam logic [1:0] C_WAIT   = 2'b00;
    localparam logic [1:0] C_NAP    = 2'b01;
    localparam logic [1:0] C_SAMPLE = 2'b10;
    localparam logic [1:0] C_CONV   = 2'b11;

    logic armed;
    int   run_len;

    // Marks cycles whose $past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(sel_n)) |-> $stable(qual_start));

    // R2
    latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(sel_n)) |-> (qual_start == $past(start_req)));

    // R3
    idle_to_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == C_WAIT || phase == C_NAP) && start_req && !sel_n) |=> (phase == C_SAMPLE));

    // R4
    fall_starts_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && phase == C_SAMPLE && $past(qual_start) && !qual_start) |=> (phase == C_CONV));

    // R5
    busy_matches_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (phase == C_CONV));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(busy)) |-> (run_len == CONV_CYCLES));

    // R9
    busy_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < CONV_CYCLES));

    // R6
    chain_to_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(busy) && $past(start_req) && !$past(sel_n)) |-> (phase == C_SAMPLE));

    // R7
    end_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(busy) && !($past(start_req) && !$past(sel_n))) |-> (phase == C_WAIT));

    // R8
    nap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && phase == C_NAP && $past(phase) != C_NAP) |-> ($past(phase) == C_WAIT));

    // R4
    conv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(busy)) |-> ($past(phase) == C_SAMPLE));

endmodule

bind convphase_seq convphase_seq_chk #(
    .CONV_CYCLES (CONV_CYCLES),
    .NAP_IDLE    (NAP_IDLE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .sel_n      (sel_n),
    .busy       (busy),
    .qual_start (qual_start),
    .phase      (phase)
);

// File: tb/convphase_seq_bench.sv
`timescale 1ns/1ps
// Bench for convphase_seq: directed corner cases followed by seeded
// random stimulus, compared every cycle against a requirement model.
module convphase_seq_bench;

    localparam int CONV = 20;
    localparam int NAPI = 64;
    localparam logic [1:0] E_WAIT   = 2'b00;
    localparam logic [1:0] E_NAP    = 2'b01;
    localparam logic [1:0] E_SAMPLE = 2'b10;
    localparam logic [1:0] E_CONV   = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       sel_n = 1'b1;
    logic       busy;
    logic       qual_start;
    logic [1:0] phase;

    int vectors = 0;
    int fails   = 0;
    int obs_run = 0;
    string cur_tag = "R1";

    // Requirement model state.
    logic [1:0] m_ph  = E_WAIT;
    int         m_cnt = 0;
    logic       m_q   = 1'b0;
    logic       m_qp  = 1'b0;

    always #2.5 clk = ~clk;

    convphase_seq #(.CONV_CYCLES(CONV), .NAP_IDLE(NAPI)) u_convphase_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .sel_n      (sel_n),
        .busy       (busy),
        .qual_start (qual_start),
        .phase      (phase)
    );

    function automatic logic [1:0] ref_next(input logic [1:0] ph, input logic go,
                                            input logic fl, input int cnt);
        case (ph)
            E_WAIT:   return go ? E_SAMPLE : ((cnt == NAPI - 1) ? E_NAP : E_WAIT);
            E_NAP:    return go ? E_SAMPLE : E_NAP;
            E_SAMPLE: return fl ? E_CONV : E_SAMPLE;
            default:  return (cnt == CONV - 1) ? (go ? E_SAMPLE : E_WAIT) : E_CONV;
        endcase
    endfunction

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic cv, input logic cs);
        logic [1:0] nx;
        nx = ref_next(m_ph, cv & ~cs, m_qp & ~m_q, m_cnt);
        m_cnt = (nx == m_ph) ? m_cnt + 1 : 0;
        m_ph  = nx;
        m_qp  = m_q;
        if (!cs) m_q = cv;
    endtask

    task automatic compare();
        chk({cur_tag, " R10 phase"}, phase === m_ph, phase, m_ph);
        chk("R5 busy", busy === (m_ph == E_CONV), busy, m_ph == E_CONV);
        chk("R2 qual", qual_start === m_q, qual_start, m_q);
        if (busy === 1'b1) begin
            obs_run++;
        end else if (obs_run != 0) begin
            chk("R5 R9 busy length", obs_run == CONV, obs_run, CONV);
            obs_run = 0;
        end
    endtask

    task automatic cycle(input logic cv, input logic cs);
        start_req = cv;
        sel_n     = cs;
        @(posedge clk);
        model_step(cv, cs);
        @(negedge clk);
        compare();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        chk("R1 reset phase", phase === E_WAIT, phase, E_WAIT);
        chk("R1 reset busy", busy === 1'b0, busy, 0);
        chk("R1 reset qual", qual_start === 1'b0, qual_start, 0);
        rst_n = 1'b1;

        // R8: idle long enough to nap.
        cur_tag = "R8";
        repeat (NAPI + 4) cycle(1'b0, 1'b1);
        chk("R8 R10 nap code", phase === E_NAP, phase, E_NAP);

        // R2: request toggles with select high are not seen.
        cur_tag = "R2";
        cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        chk("R2 held while deselected", qual_start === 1'b0, qual_start, 0);

        // R3: start condition from nap.
        cur_tag = "R3";
        cycle(1'b1, 1'b0);
        chk("R3 nap to sample", phase === E_SAMPLE, phase, E_SAMPLE);
        chk("R2 qual follows", qual_start === 1'b1, qual_start, 1);

        // R4: falling edge of qualified signal.
        cur_tag = "R4";
        cycle(1'b0, 1'b0);
        chk("R4 not yet converting", phase === E_SAMPLE, phase, E_SAMPLE);
        cycle(1'b0, 1'b0);
        chk("R4 convert entered", phase === E_CONV && busy === 1'b1, phase, E_CONV);

        // R9: mid-conversion falling edge ignored; then R7 end to wait.
        cur_tag = "R9";
        cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        for (int i = 0; i < 2 * CONV && busy === 1'b1; i++) cycle(1'b0, 1'b0);
        chk("R7 end to wait", phase === E_WAIT, phase, E_WAIT);

        // R6: back-to-back chaining.
        cur_tag = "R6";
        cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        for (int i = 0; i < 2 * CONV && busy === 1'b1; i++) cycle(1'b1, 1'b0);
        chk("R6 chained to sample", phase === E_SAMPLE, phase, E_SAMPLE);
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        chk("R6 second conversion", busy === 1'b1, busy, 1);

        // Seeded random traffic with sticky inputs.
        cur_tag = "R3 R4 R6 R7 R8";
        begin
            logic cv = 1'b0;
            logic cs = 1'b0;
            for (int n = 0; n < 6000; n++) begin
                if ($urandom_range(0, 9) == 0) cs = ~cs;
                if ($urandom_range(0, 5) == 0) cv = ~cv;
                if (n % 1500 > 1350) cs = 1'b1;
                cycle(cv, cs);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule